// File: doc/BRIEF.md
# Buffered Single-Slope PWM Timer

This block makes one pulse-width-modulated output from a free-running up-counter. The counter climbs from zero to a programmable top value and then drops back to zero. A prescaler in front of it slows the count rate by a selectable power of two. The top value therefore sets both the PWM frequency and the duty resolution. The output frequency is the clock frequency divided by (divider × (top + 1)).

Both the top value and the duty threshold are written into holding registers. They are copied into the working registers only when the counter returns to zero, and once when the timer is switched on. A duty or period change made in the middle of a period therefore never cuts a pulse short or stretches it. A one-clock cycle-start strobe marks the first clock of every period, so surrounding logic can align its own updates with the period boundary.

Top module: `pwm_slope_timer`

## Requirements
- R1: After a synchronous active-low reset, `pwm_out` and `cycle_start` are both 0.
- R2: While `enable` is low, `pwm_out` and `cycle_start` stay 0, whatever values are held in the buffers.
- R3: With divider 1, `cycle_start` pulses once every (top + 1) clocks. The counter runs 0, 1, …, top and then returns to 0.
- R4: `presc_sel` codes 0 to 7 give dividers 1, 2, 4, 8, 16, 64, 256 and 1024. The counter advances once per divider clocks, so a period lasts divider × (top + 1) clocks.
- R5: If the working threshold is below the top value, `pwm_out` is high for the first threshold × divider clocks of each period and low for the rest.
- R6: A threshold of 0 with a nonzero top keeps `pwm_out` low for the whole period.
- R7: A threshold equal to or above the top value keeps `pwm_out` high for the whole period. This rule wins over R6 when the top is 0.
- R8: A threshold write during a period does not change that period's output. The new value governs the period that follows.
- R9: A top-value write during a period does not change that period's length, even when the new top is below the current count. The new length applies from the next period.
- R10: The first clock edge that samples `enable` high loads both buffers into the working registers and clears the count. `cycle_start` is high in the clock that follows, and `pwm_out` then already reflects the loaded threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Run the timer when high |
| presc_sel | input | 3 | Divider code (see R4) |
| per_wr | input | 1 | Write strobe for the top-value buffer |
| per_wdata | input | CNT_W | New top value |
| cmp_wr | input | 1 | Write strobe for the threshold buffer |
| cmp_wdata | input | CNT_W | New duty threshold |
| pwm_out | output | 1 | PWM waveform |
| cycle_start | output | 1 | One-clock strobe on the first clock of each period |

## Verification
The bench measures whole periods between strobes and counts the high clocks in each, across every divider code. A divider decoded wrongly shows up as a wrong period length. An off-by-one in the wrap compare lengthens or shortens every period by one tick. The end-of-range thresholds (0, equal to top, above top, top of 0) catch a comparator that leaks a one-tick sliver or drops the forced-high rule. Writes made mid-period, including a top smaller than the running count, catch unbuffered updates: the period being measured would change length or duty, or the counter would run past the new top and wrap only after overflowing.

// File: rtl/pwm_timer_pkg.sv
// Package: shared types for the PWM timer.
// Assumes: the divider code is 3 bits wide and decodes to powers of two.
package pwm_timer_pkg;

    localparam int PSEL_W = 3;

    typedef enum logic [PSEL_W-1:0] {
        PS_DIV1    = 3'd0,
        PS_DIV2    = 3'd1,
        PS_DIV4    = 3'd2,
        PS_DIV8    = 3'd3,
        PS_DIV16   = 3'd4,
        PS_DIV64   = 3'd5,
        PS_DIV256  = 3'd6,
        PS_DIV1024 = 3'd7
    } presc_e;

    // log2 of the divider: codes 0..4 map straight across, 5..7 step by two.
    function automatic int unsigned presc_shift(presc_e sel);
        int unsigned s;
        s = int'(sel);
        return (s < 5) ? s : (2 * s - 4);
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
// Module: pwm_prescaler
// Produces a one-clock count tick every 2^shift clocks while running.
// Assumes: PRE_W is wide enough for the largest divider minus one.
module pwm_prescaler
    import pwm_timer_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run,
    input  presc_e sel,
    output logic   tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] last;

    // Terminal value of the divider for the selected code.
    always_comb last = PRE_W'((32'd1 << presc_shift(sel)) - 32'd1);

    // A tick fires at or past the terminal value, which also covers a code change mid-count.
    always_comb tick = run && (pre_q >= last);

    // Divider count: cleared while stopped and after every tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R4: a tick is never followed by a second one in the next clock unless the divider is 1.
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != PS_DIV1 && $stable(sel)) |=> !tick);

endmodule

// File: rtl/pwm_period_counter.sv
// Module: pwm_period_counter
// Up-counter from 0 to a buffered top value. Emits the load strobe for all
// working registers on start-up and at each wrap, and registers the period strobe.
// Assumes: tick is low while the counter is not running.
module pwm_period_counter #(
    parameter int CNT_W   = 16,
    parameter int RST_PER = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_wdata,
    output logic             run,
    output logic             load,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per_act,
    output logic             cstart
);

    logic [CNT_W-1:0] per_buf;
    logic             start;
    logic             wrap;

    // Start-up is the first enabled clock. A wrap is a tick taken at the top value.
    always_comb begin
        start = enable && !run;
        wrap  = run && tick && (cnt == per_act);
        load  = start || wrap;
    end

    // Running flag: the enable sampled one clock earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) run <= 1'b0;
        else        run <= enable;
    end

    // Count register: held at zero while stopped, advanced only on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt <= '0;
        end else if (start || wrap) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Top-value holding register, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)      per_buf <= CNT_W'(RST_PER);
        else if (per_wr) per_buf <= per_wdata;
    end

    // Working top value: copied from the holding register only on load.
    always_ff @(posedge clk) begin
        if (!rst_n)    per_act <= CNT_W'(RST_PER);
        else if (load) per_act <= per_buf;
    end

    // Period strobe: high in the first clock of each period.
    always_ff @(posedge clk) begin
        if (!rst_n) cstart <= 1'b0;
        else        cstart <= load && enable;
    end

    // R3: the count never exceeds the working top.
    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= per_act));

    // R3: the strobe coincides with a zero count.
    p_strobe_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cstart |-> (cnt == '0));

    // R4: without a tick and a load the count holds.
    p_hold_between_ticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && run && !tick) |=> $stable(cnt));

    // R9: the working top only moves on a load.
    p_top_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(per_act));

endmodule

// File: rtl/pwm_compare.sv
// Module: pwm_compare
// Holds the buffered duty threshold and decodes the PWM level from the count.
// Assumes: load pulses at start-up and at every wrap of the counter.
module pwm_compare #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] per_act,
    output logic             pwm
);

    logic [CNT_W-1:0] cmp_buf;
    logic [CNT_W-1:0] cmp_act;
    logic             force_hi;

    // Threshold holding register, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_buf <= '0;
        else if (cmp_wr) cmp_buf <= cmp_wdata;
    end

    // Working threshold: copied only at period boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n)    cmp_act <= '0;
        else if (load) cmp_act <= cmp_buf;
    end

    // Level decode: forced high at or above the top, otherwise high below the threshold.
    always_comb begin
        force_hi = (cmp_act >= per_act);
        pwm      = run && (force_hi || (cnt < cmp_act));
    end

    // R8: the working threshold changes only on a load.
    p_duty_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cmp_act));

endmodule

// File: rtl/pwm_slope_timer.sv
// Module: pwm_slope_timer (top)
// Single-slope PWM timer with buffered top and duty registers.
// Assumes: all inputs are synchronous to clk.
module pwm_slope_timer #(
    parameter int CNT_W   = 16,
    parameter int PRE_W   = 10,
    parameter int RST_PER = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [2:0]       presc_sel,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic             pwm_out,
    output logic             cycle_start
);

    import pwm_timer_pkg::*;

    logic             run;
    logic             tick;
    logic             load;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] per_act;
    presc_e           sel;

    // Divider code into the shared enum.
    always_comb sel = presc_e'(presc_sel);

    pwm_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .sel  (sel),
        .tick (tick)
    );

    pwm_period_counter #(.CNT_W(CNT_W), .RST_PER(RST_PER)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .tick     (tick),
        .per_wr   (per_wr),
        .per_wdata(per_wdata),
        .run      (run),
        .load     (load),
        .cnt      (cnt),
        .per_act  (per_act),
        .cstart   (cycle_start)
    );

    pwm_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .load     (load),
        .cmp_wr   (cmp_wr),
        .cmp_wdata(cmp_wdata),
        .cnt      (cnt),
        .per_act  (per_act),
        .pwm      (pwm_out)
    );

    // R2: one clock after enable is seen low, both outputs are quiet.
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!enable) |-> (!pwm_out && !cycle_start));

    // R10: the first enabled edge is followed by a period strobe.
    p_start_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !run) |=> cycle_start);

endmodule

// File: tb/test_pwm_slope_timer.sv
// Bench for pwm_slope_timer: a vector table walked by one loop, then directed cases.
module test_pwm_slope_timer;

    localparam time CLK_P = 10ns;
    localparam int  CW    = 16;

    typedef struct packed {
        logic [2:0]  sel;
        logic [15:0] per;
        logic [15:0] cmp;
        logic [31:0] len;
        logic [31:0] hi;
    } vec_t;

    // Period length = divider*(top+1); high time = threshold*divider, or all when threshold >= top.
    localparam vec_t VECS [12] = '{
        '{3'd0, 16'd9, 16'd5,  32'd10,   32'd5},
        '{3'd0, 16'd9, 16'd0,  32'd10,   32'd0},
        '{3'd0, 16'd9, 16'd9,  32'd10,   32'd10},
        '{3'd0, 16'd9, 16'd12, 32'd10,   32'd10},
        '{3'd1, 16'd7, 16'd3,  32'd16,   32'd6},
        '{3'd2, 16'd4, 16'd2,  32'd20,   32'd8},
        '{3'd3, 16'd3, 16'd1,  32'd32,   32'd8},
        '{3'd4, 16'd2, 16'd1,  32'd48,   32'd16},
        '{3'd5, 16'd1, 16'd1,  32'd128,  32'd128},
        '{3'd6, 16'd3, 16'd2,  32'd1024, 32'd512},
        '{3'd7, 16'd1, 16'd0,  32'd2048, 32'd0},
        '{3'd0, 16'd0, 16'd0,  32'd1,    32'd1}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          enable;
    logic [2:0]    presc_sel;
    logic          per_wr;
    logic [CW-1:0] per_wdata;
    logic          cmp_wr;
    logic [CW-1:0] cmp_wdata;
    logic          pwm_out;
    logic          cycle_start;

    int checks = 0;
    int errors = 0;

    always #(CLK_P / 2) clk = ~clk;

    pwm_slope_timer #(.CNT_W(CW)) i_pwm_slope_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .presc_sel  (presc_sel),
        .per_wr     (per_wr),
        .per_wdata  (per_wdata),
        .cmp_wr     (cmp_wr),
        .cmp_wdata  (cmp_wdata),
        .pwm_out    (pwm_out),
        .cycle_start(cycle_start)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Load both buffers while stopped, then start the timer.
    task automatic program_run(input logic [2:0] s, input logic [CW-1:0] p, input logic [CW-1:0] c);
        @(negedge clk);
        enable    = 1'b0;
        presc_sel = s;
        per_wr    = 1'b1;
        per_wdata = p;
        cmp_wr    = 1'b1;
        cmp_wdata = c;
        @(negedge clk);
        per_wr = 1'b0;
        cmp_wr = 1'b0;
        @(negedge clk);
        enable = 1'b1;
    endtask

    // Measure one period from a strobe to the next. Optionally write a buffer at offset 3.
    task automatic measure(input bit do_wr, input bit to_per, input logic [CW-1:0] val,
                           output int len, output int hi);
        @(negedge clk);
        while (!cycle_start) @(negedge clk);
        len = 0;
        hi  = 0;
        do begin
            if (do_wr && len == 3) begin
                if (to_per) begin per_wr = 1'b1; per_wdata = val; end
                else        begin cmp_wr = 1'b1; cmp_wdata = val; end
            end else begin
                per_wr = 1'b0;
                cmp_wr = 1'b0;
            end
            len++;
            if (pwm_out) hi++;
            @(negedge clk);
        end while (!cycle_start);
        per_wr = 1'b0;
        cmp_wr = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_P * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int len;
        int hi;
        int seen;
        rst_n = 1'b0; enable = 1'b0; presc_sel = 3'd0;
        per_wr = 1'b0; per_wdata = '0; cmp_wr = 1'b0; cmp_wdata = '0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in and after reset.
        chk("R1 pwm_out", int'(pwm_out), 0);
        chk("R1 cycle_start", int'(cycle_start), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pwm_out after release", int'(pwm_out), 0);

        // Table walk: R3 to R7 across every divider code.
        foreach (VECS[i]) begin
            program_run(VECS[i].sel, VECS[i].per, VECS[i].cmp);
            measure(1'b0, 1'b0, '0, len, hi);
            chk(VECS[i].sel == 3'd0 ? "R3 period" : "R4 period", len, int'(VECS[i].len));
            chk(VECS[i].hi == 0 ? "R6 high" : (VECS[i].hi == VECS[i].len ? "R7 high" : "R5 high"),
                hi, int'(VECS[i].hi));
        end

        // R2: stopped with a forced-high threshold buffered, nothing toggles.
        @(negedge clk);
        enable    = 1'b0;
        per_wr    = 1'b1; per_wdata = 16'd9;
        cmp_wr    = 1'b1; cmp_wdata = 16'd12;
        presc_sel = 3'd0;
        @(negedge clk);
        per_wr = 1'b0; cmp_wr = 1'b0;
        seen = 0;
        for (int k = 0; k < 20; k++) begin
            if (pwm_out || cycle_start) seen++;
            @(negedge clk);
        end
        chk("R2 idle activity", seen, 0);

        // R10: the first clock after enabling already shows the strobe and the loaded level.
        program_run(3'd0, 16'd9, 16'd5);
        @(negedge clk);
        chk("R10 cycle_start", int'(cycle_start), 1);
        chk("R10 pwm_out", int'(pwm_out), 1);

        // R8: threshold write mid-period, from 2 to 7.
        program_run(3'd0, 16'd9, 16'd2);
        measure(1'b1, 1'b0, 16'd7, len, hi);
        chk("R8 current high", hi, 2);
        measure(1'b0, 1'b0, '0, len, hi);
        chk("R8 next high", hi, 7);

        // R9: top shrinks from 9 to 3 while the count is past 3.
        program_run(3'd0, 16'd9, 16'd2);
        measure(1'b1, 1'b1, 16'd3, len, hi);
        chk("R9 current period", len, 10);
        measure(1'b0, 1'b0, '0, len, hi);
        chk("R9 next period", len, 4);
        chk("R9 next high", hi, 2);

        // R1: reset while running returns both outputs to 0.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 pwm_out mid-run", int'(pwm_out), 0);
        chk("R1 cycle_start mid-run", int'(cycle_start), 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule